// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans a switch matrix of eight rows and five columns. It enables one row at a time and, after that row has had time to settle, reads the five column lines. Each key passes through its own debounce filter. For every row visited, the scanner puts out one byte. The byte holds the filtered state of all keys on that row and the number of the row. A full pass over the matrix therefore goes out as a burst of eight bytes, and no single wide word is needed.

Several keys held on one row are all reported together, as a bitmap. The block does not turn a press into a key code. A consumer reads the row bytes as they are strobed out and watches the end-of-pass pulse to know when the image is complete. With only passive switches on the matrix, some combinations of three or more closed keys cannot be told apart, so reliable reports are promised only while at most two keys are down. No logic tries to suppress these phantom keys.

Top module: `keymat_scanner`

## Requirements
- R1: Exactly one row line is driven low at any time, and all other rows are released high. Rows are visited in ascending order 0,1,…,7 and the sequence wraps back to 0.
- R2: A row stays selected for SETTLE clock cycles (default 4) before its columns are sampled. Consecutive row bytes are therefore exactly SETTLE cycles apart.
- R3: In each output byte, bits 7:5 carry the index of the row whose keys are reported in bits 4:0.
- R4: A column line read low while a row is selected means the key at that row and column is closed. Key state for column c appears in byte bit c, with 1 meaning pressed.
- R5: When several keys on one row are closed at the same time, every one of them is set in that row's byte.
- R6: A key's reported state changes only after the new level has been sampled on DEB_SCANS consecutive scans of its row (default 3). A press held for fewer scans is never reported.
- R7: `rpt_valid` is high for exactly one cycle per row byte, and the block gives eight bytes per pass.
- R8: `frame_done` is high only together with the byte for row 7, the last row.
- R9: A synchronous reset sets every filtered key state to released, drives row 0 low, and keeps `rpt_valid` and `frame_done` low. After reset, scanning restarts at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_drv_n | output | 8 | Row select lines, active low |
| col_sense_n | input | 5 | Column sense lines with pull-ups, low when a key is closed |
| rpt_byte | output | 8 | Row report: key bitmap in 4:0, row index in 7:5 |
| rpt_valid | output | 1 | One-cycle strobe that qualifies `rpt_byte` |
| frame_done | output | 1 | Pulse together with the last row's byte of a pass |

## Verification
The embedded assertions check a set of properties on every cycle:
- the row counter advances by one and wraps at each sample;
- the row holds between samples;
- the settle and debounce counters stay in bounds;
- a filtered key state changes only on a sample of its own row;
- the strobe is a single cycle;
- the row field of the byte matches the row just sampled;
- the end-of-pass pulse is tagged with the last row;
- reset clears every key.

Only the bench scenarios can show the full behaviour through the pins. These scenarios cover:
- the debounce delay counted in whole scans;
- a short press that is swallowed;
- a full row of keys pressed at once;
- keys on separate rows being kept apart;
- a reset in the middle of a run while keys are still held.

// File: rtl/kpscan_pkg.sv
package kpscan_pkg;

   // Width of an index that counts 0..n-1, never less than one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Default geometry and timing of the scanner.
   localparam int unsigned DEF_ROWS        = 8;
   localparam int unsigned DEF_COLS        = 5;
   localparam int unsigned DEF_SETTLE      = 4;
   localparam int unsigned DEF_DEB_SCANS   = 3;
   localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/kpscan_row_seq.sv
module kpscan_row_seq
   import kpscan_pkg::*;
#(
   parameter int unsigned ROWS           = DEF_ROWS,
   parameter int unsigned SETTLE         = DEF_SETTLE,
   parameter bit          ROW_ACTIVE_LOW = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   output logic [idx_w(ROWS)-1:0]   row_idx,
   output logic                     sample_stb,
   output logic [ROWS-1:0]          row_drv
);
   localparam int unsigned ROW_W  = idx_w(ROWS);
   localparam int unsigned TICK_W = idx_w(SETTLE);
   localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
   localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SETTLE - 1);

   logic [ROW_W-1:0]  row_q;
   logic [TICK_W-1:0] tick_q;
   logic [ROWS-1:0]   onehot;

   assign sample_stb = (tick_q == LAST_TICK);
   assign row_idx    = row_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q  <= '0;
         tick_q <= '0;
      end else if (sample_stb) begin
         tick_q <= '0;
         row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   assign onehot = ROWS'(1) << row_q;

   generate
      if (ROW_ACTIVE_LOW) begin : g_drv_low
         assign row_drv = ~onehot;
      end else begin : g_drv_high
         assign row_drv = onehot;
      end
   endgenerate

   // R1: the row index advances by one and wraps on each sample
   a_r1_row_advance: assert property (@(posedge clk) disable iff (rst)
      sample_stb |=> (row_q == (($past(row_q) == LAST_ROW) ? '0 : $past(row_q) + 1'b1)));

   // R2: the row stays put while it is settling
   a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
      !sample_stb |=> $stable(row_q));

   // R2: the settle counter never passes its limit
   a_r2_tick_bound: assert property (@(posedge clk) disable iff (rst)
      tick_q <= LAST_TICK);

   // R1: the row index stays inside the matrix
   a_r1_row_bound: assert property (@(posedge clk) disable iff (rst)
      row_q <= LAST_ROW);

endmodule

// File: rtl/kpscan_key_filter.sv
module kpscan_key_filter
   import kpscan_pkg::*;
#(
   parameter int unsigned DEB_SCANS = DEF_DEB_SCANS
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_en,
   input  logic raw_on,
   output logic state_q,
   output logic state_nxt
);
   generate
      if (DEB_SCANS == 1) begin : g_direct
         // No filtering: the level seen on each scan is accepted at once.
         assign state_nxt = sample_en ? raw_on : state_q;
      end else begin : g_counted
         localparam int unsigned CNT_W = idx_w(DEB_SCANS);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_SCANS - 1);

         logic [CNT_W-1:0] cnt_q, cnt_nxt;
         logic             st_nxt;

         always_comb begin
            st_nxt  = state_q;
            cnt_nxt = cnt_q;
            if (sample_en) begin
               if (raw_on == state_q) begin
                  cnt_nxt = '0;
               end else if (cnt_q == CNT_LAST) begin
                  st_nxt  = raw_on;
                  cnt_nxt = '0;
               end else begin
                  cnt_nxt = cnt_q + 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_nxt;
         end

         assign state_nxt = st_nxt;

         // R6: the run-length counter stays below the acceptance count
         a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= CNT_LAST);

         // R6: the counter only moves on a scan of this key
         a_r6_count_idle: assert property (@(posedge clk) disable iff (rst)
            !sample_en |=> $stable(cnt_q));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) state_q <= 1'b0;
      else     state_q <= state_nxt;
   end

   // R6: an accepted state changes only right after a scan of its row
   a_r6_change_on_scan: assert property (@(posedge clk) disable iff (rst)
      !$stable(state_q) |-> $past(sample_en));

endmodule

// File: rtl/kpscan_report.sv
module kpscan_report
   import kpscan_pkg::*;
#(
   parameter int unsigned ROWS = DEF_ROWS,
   parameter int unsigned COLS = DEF_COLS
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           sample_stb,
   input  logic [idx_w(ROWS)-1:0]         row_idx,
   input  logic [COLS-1:0]                row_keys,
   output logic [idx_w(ROWS)+COLS-1:0]    rpt_byte,
   output logic                           rpt_valid,
   output logic                           frame_done
);
   localparam int unsigned ROW_W = idx_w(ROWS);
   localparam int unsigned OUT_W = ROW_W + COLS;
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

   logic [OUT_W-1:0] byte_q;
   logic             valid_q, done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         byte_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         valid_q <= sample_stb;
         done_q  <= sample_stb && (row_idx == LAST_ROW);
         if (sample_stb) byte_q <= {row_idx, row_keys};
      end
   end

   assign rpt_byte   = byte_q;
   assign rpt_valid  = valid_q;
   assign frame_done = done_q;

   // R3: the row field names the row sampled one cycle earlier
   a_r3_row_field: assert property (@(posedge clk) disable iff (rst)
      rpt_valid |-> (rpt_byte[OUT_W-1:COLS] == $past(row_idx)));

   // R8: the end-of-pass pulse rides only on the last row's byte
   a_r8_frame_tag: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> (rpt_valid && rpt_byte[OUT_W-1:COLS] == LAST_ROW));

   // R3: the byte holds steady between strobes
   a_r3_byte_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(sample_stb) |-> $stable(rpt_byte));

endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner
   import kpscan_pkg::*;
#(
   parameter int unsigned ROWS           = DEF_ROWS,
   parameter int unsigned COLS           = DEF_COLS,
   parameter int unsigned SETTLE         = DEF_SETTLE,
   parameter int unsigned DEB_SCANS      = DEF_DEB_SCANS,
   parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES,
   parameter bit          ROW_ACTIVE_LOW = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   output logic [ROWS-1:0]               row_drv_n,
   input  logic [COLS-1:0]               col_sense_n,
   output logic [$clog2(ROWS)+COLS-1:0]  rpt_byte,
   output logic                          rpt_valid,
   output logic                          frame_done
);
   localparam int unsigned ROW_W = idx_w(ROWS);
   localparam int unsigned OUT_W = ROW_W + COLS;
   localparam int unsigned KEYS  = ROWS * COLS;

   // Elaboration-time parameter checks
   if (ROWS < 2) begin : g_bad_rows
      $error("keymat_scanner: ROWS must be at least 2");
   end
   if (COLS < 1) begin : g_bad_cols
      $error("keymat_scanner: COLS must be at least 1");
   end
   if (DEB_SCANS < 1) begin : g_bad_deb
      $error("keymat_scanner: DEB_SCANS must be at least 1");
   end
   if (SETTLE < SYNC_STAGES + 1 || SETTLE < 2) begin : g_bad_settle
      $error("keymat_scanner: SETTLE must exceed the synchronizer depth and be at least 2");
   end

   // ---------------- column synchronizer ----------------
   logic [COLS-1:0] col_on;   // 1 = key closed, after synchronization

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign col_on = ~col_sense_n;
      end else begin : g_sync
         logic [COLS-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            sync_q[0] <= ~col_sense_n;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         end
         assign col_on = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // ---------------- row sequencer ----------------
   logic [ROW_W-1:0] row_idx;
   logic             sample_stb;

   kpscan_row_seq #(
      .ROWS           (ROWS),
      .SETTLE         (SETTLE),
      .ROW_ACTIVE_LOW (ROW_ACTIVE_LOW)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .row_idx    (row_idx),
      .sample_stb (sample_stb),
      .row_drv    (row_drv_n)
   );

   // ---------------- per-key filters ----------------
   logic [KEYS-1:0] key_state;
   logic [KEYS-1:0] key_nxt;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic row_hit;
         assign row_hit = sample_stb && (row_idx == ROW_W'(r));
         for (genvar c = 0; c < COLS; c++) begin : g_col
            kpscan_key_filter #(.DEB_SCANS(DEB_SCANS)) u_flt (
               .clk       (clk),
               .rst       (rst),
               .sample_en (row_hit),
               .raw_on    (col_on[c]),
               .state_q   (key_state[r*COLS + c]),
               .state_nxt (key_nxt[r*COLS + c])
            );
         end
      end
   endgenerate

   // Report the states as they stand after this scan's update.
   logic [COLS-1:0] row_keys;
   always_comb row_keys = key_nxt[int'(row_idx)*COLS +: COLS];

   // ---------------- report packer ----------------
   logic [OUT_W-1:0] byte_w;

   kpscan_report #(
      .ROWS (ROWS),
      .COLS (COLS)
   ) u_rpt (
      .clk        (clk),
      .rst        (rst),
      .sample_stb (sample_stb),
      .row_idx    (row_idx),
      .row_keys   (row_keys),
      .rpt_byte   (byte_w),
      .rpt_valid  (rpt_valid),
      .frame_done (frame_done)
   );

   assign rpt_byte = byte_w;

   // R9: reset leaves every key released and the scan back at row 0
   a_r9_reset_clear: assert property (@(posedge clk)
      rst |=> (key_state == '0 && row_idx == '0 && !rpt_valid && !frame_done));

   // R7: the strobe lasts a single cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rpt_valid |=> !rpt_valid);

   // R1: exactly one row is selected at any time
   a_r1_one_row: assert property (@(posedge clk) disable iff (rst)
      $countones(ROW_ACTIVE_LOW ? ~row_drv_n : row_drv_n) == 1);

   // R4: the key bits of a byte match the filtered state of its row
   a_r4_bits_match: assert property (@(posedge clk) disable iff (rst)
      rpt_valid |-> (rpt_byte[COLS-1:0] ==
                     key_state[int'(rpt_byte[OUT_W-1:COLS])*COLS +: COLS]));

endmodule

// File: tb/keymat_scanner_tb_top.sv
module keymat_scanner_tb_top;
   localparam int NR = 8;
   localparam int NC = 5;
   localparam int ST = 4;
   localparam int DB = 3;
   localparam int BW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          rst = 1'b1;
   logic [NR-1:0] row_drv_n;
   logic [NC-1:0] col_sense_n;
   logic [BW-1:0] rpt_byte;
   logic          rpt_valid;
   logic          frame_done;

   keymat_scanner dut_i (
      .clk         (clk),
      .rst         (rst),
      .row_drv_n   (row_drv_n),
      .col_sense_n (col_sense_n),
      .rpt_byte    (rpt_byte),
      .rpt_valid   (rpt_valid),
      .frame_done  (frame_done)
   );

   // Physical matrix: a closed key ties its column to its row line.
   logic [NC-1:0] keys [NR];
   always_comb begin
      col_sense_n = '1;
      for (int r = 0; r < NR; r++)
         if (!row_drv_n[r]) col_sense_n = col_sense_n & ~keys[r];
   end

   // Reference filter model and scoreboard
   logic [NC-1:0] m_state [NR];
   int            m_cnt [NR][NC];
   typedef struct { logic [BW-1:0] b; logic fd; } exp_t;
   exp_t q[$];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic model_clear();
      for (int r = 0; r < NR; r++) begin
         m_state[r] = '0;
         for (int c = 0; c < NC; c++) m_cnt[r][c] = 0;
      end
   endtask

   // Driver: one full pass with the current key pattern
   task automatic run(input int n);
      repeat (n) begin
         for (int r = 0; r < NR; r++) begin
            exp_t e;
            for (int c = 0; c < NC; c++) begin
               if (keys[r][c] == m_state[r][c]) m_cnt[r][c] = 0;
               else if (m_cnt[r][c] == DB - 1) begin
                  m_state[r][c] = keys[r][c];
                  m_cnt[r][c]   = 0;
               end else m_cnt[r][c]++;
            end
            e.b  = {3'(r), m_state[r]};
            e.fd = (r == NR - 1);
            q.push_back(e);
         end
         do @(negedge clk); while (!(rpt_valid && frame_done));
      end
   endtask

   // Monitor
   bit prev_v  = 1'b0;
   int last_v  = -1;
   always @(negedge clk) begin
      if (rst) begin
         prev_v = 1'b0;
         last_v = -1;
      end else begin
         if (rpt_valid) begin
            check(!prev_v, "R7 strobe longer than one cycle", 1, 0);
            if (last_v >= 0) check(cyc - last_v == ST, "R2 byte spacing", cyc - last_v, ST);
            last_v = cyc;
            if (q.size() == 0) begin
               check(1'b0, "R7 byte with nothing expected", rpt_byte, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(rpt_byte[NC-1:0] == e.b[NC-1:0], "R4 R5 R6 key bits",
                     rpt_byte[NC-1:0], e.b[NC-1:0]);
               check(rpt_byte[BW-1:NC] == e.b[BW-1:NC], "R3 row field",
                     rpt_byte[BW-1:NC], e.b[BW-1:NC]);
               check(frame_done == e.fd, "R8 frame_done", frame_done, e.fd);
               check(row_drv_n == ~(NR'(1) << ((int'(rpt_byte[BW-1:NC]) + 1) % NR)),
                     "R1 next row driven", row_drv_n,
                     ~(NR'(1) << ((int'(rpt_byte[BW-1:NC]) + 1) % NR)));
            end
         end else begin
            check(!frame_done, "R8 frame_done without byte", frame_done, 0);
         end
         prev_v = rpt_valid;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=timeout expected=frame_done");
      finish_run();
   end

   initial begin
      for (int r = 0; r < NR; r++) keys[r] = '0;
      model_clear();
      repeat (3) @(negedge clk);
      // R9: state under reset
      check(row_drv_n == 8'hFE, "R9 reset row drive", row_drv_n, 8'hFE);
      check(!rpt_valid, "R9 reset valid", rpt_valid, 0);
      check(!frame_done, "R9 reset frame_done", frame_done, 0);
      rst = 1'b0;

      run(2);                          // idle matrix
      keys[0][0] = 1'b1; run(4);       // R6: accepted on the third scan
      keys[3] = 5'h1F; keys[7][4] = 1'b1; run(4);   // R5: full row plus another row
      keys[5][2] = 1'b1; run(2);       // R6: short press, swallowed
      keys[5][2] = 1'b0; run(3);
      keys[0][0] = 1'b0; run(4);       // release after debounce
      keys[1][1] = 1'b1; keys[6][3] = 1'b1; run(4); // R4: two rows kept apart

      // R9: reset mid-run with keys still held
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(row_drv_n == 8'hFE, "R9 mid-run reset row drive", row_drv_n, 8'hFE);
      check(!rpt_valid, "R9 mid-run reset valid", rpt_valid, 0);
      q.delete();
      model_clear();
      rst = 1'b0;
      run(4);                          // held keys must be re-debounced

      @(negedge clk);
      check(q.size() == 0, "R7 bytes missing at end", q.size(), 0);
      finish_run();
   end

endmodule